// File: doc/BRIEF.md
# Expansion-Window Ownership and Column-Mode Decoder

This block sits on the bus side of a peripheral card plugged into slot 3 of an 8-bit backplane with a 16-bit address bus. It watches every bus cycle and keeps two pieces of state. The first is a display-mode flag that picks between native 40-column video and the card's own 80-column rendering. The second is an ownership flag for the shared expansion space at $C800–$CFFF. Only one card may answer in that space at a time, so the card claims it when the CPU touches the card's own slot ROM page. It gives the space up when the CPU strobes $CFFF or touches the ROM page of some other slot.

All ownership decoding is qualified by the phase-0 level of the bus clock and not by the backplane's I/O strobe. Glitch addresses that appear while phase 0 is low therefore do nothing. An internal-ROM override input masks the window without losing the ownership flag. From the flag and the override the block derives a window-active output. It also derives two select strobes: one for the expansion ROM and one for the video RAM window at $CC00–$CDFF. The surrounding card logic uses these to drive its data bus.

Top module: `xrom_own_decoder`

## Requirements
- R1: While phase0 is high, an access to the card's own slot page ($C300–$C3FF for SLOT=3) sets the ownership flag. The override input does not block this.
- R2: While phase0 is high, an access to $CFFF clears ownership only when int_cx_rom is low. With int_cx_rom high, $CFFF leaves ownership unchanged.
- R3: While phase0 is high, an access to any other slot page ($C100–$C7FF except the own page) clears ownership. Pages $C0xx and $C8xx–$CFxx, other than $CFFF, do not affect it.
- R4: While phase0 is low, no address changes ownership. This includes $CFFF and every slot page.
- R5: Within one phase-0 window only the first ownership event takes effect. If set and clear conditions coincide, the own-page set wins. Later events are ignored until phase0 falls.
- R6: xwin_active is 1 exactly when ownership is held and int_cx_rom is 0.
- R7: vram_sel is 1 exactly when phase0 is high, xwin_active is 1 and the address lies in $CC00–$CDFF.
- R8: rom_sel is 1 exactly when phase0 is high, xwin_active is 1 and the address lies in $C800–$CBFF or $CE00–$CFFE. At $CFFF, rom_sel is always 0.
- R9: On a clock with phase1_rise high and mb_sel_n low, address $C058 clears mode80 and $C059 sets it. On any other clock, mode80 holds.
- R10: Asserting the active-low rst_n asynchronously clears both ownership and mode80, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| phase0 | input | 1 | Bus phase-0 level qualifier |
| phase1_rise | input | 1 | One-clock pulse at the rising edge of phase 1 |
| mb_sel_n | input | 1 | Active-low motherboard-select qualifier for soft switches |
| int_cx_rom | input | 1 | Internal-ROM override; masks the expansion window |
| addr | input | ADDR_W | Bus address |
| mode80 | output | 1 | 1 = 80-column rendering, 0 = native 40-column pass-through |
| xwin_active | output | 1 | Expansion window is owned and not overridden |
| rom_sel | output | 1 | Expansion ROM select strobe |
| vram_sel | output | 1 | Video RAM window select strobe |

## Verification
The bench builds the block with its default values: a 16-bit address, SLOT=3 and the mode switch pair at $C058/$C059. These values put the exact decode edges within reach: $CBFF and $CC00, $CDFF and $CE00, $CFFE and $CFFF, and the slot pages on either side of $C3xx. Directed sequences also place two conflicting ownership events inside one phase-0 window. A long run of mixed addresses then uses a weighted pool that keeps the own page, $CFFF and the other slot pages frequent.

// File: rtl/xrom_own_pkg.sv
package xrom_own_pkg;

    // Address classification produced once per cycle and shared by the trackers.
    typedef struct packed {
        logic own_page;    // card's own slot ROM page
        logic other_page;  // some other slot's ROM page
        logic cfff;        // the release strobe address
        logic rom_lo;      // lower expansion ROM region
        logic vram;        // video RAM window
        logic rom_hi;      // upper expansion ROM region, strobe excluded
        logic mode_off;    // 40-column soft switch
        logic mode_on;     // 80-column soft switch
    } addr_class_t;

    typedef struct packed {
        logic own;   // expansion space ownership
        logic done;  // an ownership event already acted in this phase-0 window
    } own_state_t;

    typedef struct packed {
        logic mode80;
    } mode_state_t;

endpackage

// File: rtl/xrom_addr_class.sv
module xrom_addr_class
    import xrom_own_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 SLOT      = 3,
    parameter logic [ADDR_W-1:0]  MODE_BASE = 16'hC058
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_t       cls
);
    localparam int              PG_W    = 8;
    localparam int              PG_LSB  = ADDR_W - PG_W;
    localparam int              NSLOT   = 7;
    localparam logic [3:0]      IO_NIB  = 4'hC;
    localparam logic [ADDR_W-1:0] STROBE = {IO_NIB, {(ADDR_W-4){1'b1}}};

    logic [PG_W-1:0]  page;
    logic [NSLOT:1]   slot_hit;
    logic [NSLOT:1]   foreign_hit;

    assign page = addr[ADDR_W-1:PG_LSB];

    generate
        for (genvar s = 1; s <= NSLOT; s++) begin : g_slot
            assign slot_hit[s]    = (page == {IO_NIB, 4'(s)});
            assign foreign_hit[s] = (s != SLOT) && slot_hit[s];
        end
    endgenerate

    always_comb begin
        cls            = '0;
        cls.own_page   = slot_hit[SLOT];
        cls.other_page = |foreign_hit;
        cls.cfff       = (addr == STROBE);
        cls.rom_lo     = (page[7:2] == 6'b110010);
        cls.vram       = (page[7:1] == 7'b1100110);
        cls.rom_hi     = (page[7:1] == 7'b1100111) && !cls.cfff;
        cls.mode_off   = (addr == MODE_BASE);
        cls.mode_on    = (addr == MODE_BASE + ADDR_W'(1));
    end

endmodule

// File: rtl/xrom_own_track.sv
module xrom_own_track
    import xrom_own_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase0,
    input  logic int_cx_rom,
    input  logic hit_own,
    input  logic hit_other,
    input  logic hit_cfff,
    output logic own
);
    own_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!phase0) begin
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (hit_own) begin
                st_d.own  = 1'b1;
                st_d.done = 1'b1;
            end else if ((hit_cfff && !int_cx_rom) || hit_other) begin
                st_d.own  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign own = st_q.own;

endmodule

// File: rtl/xrom_mode_latch.sv
module xrom_mode_latch
    import xrom_own_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase1_rise,
    input  logic mb_sel_n,
    input  logic hit_off,
    input  logic hit_on,
    output logic mode80
);
    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase1_rise && !mb_sel_n) begin
            if (hit_off)     st_d.mode80 = 1'b0;
            else if (hit_on) st_d.mode80 = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode80 = st_q.mode80;

endmodule

// File: rtl/xrom_own_decoder.sv
module xrom_own_decoder
    import xrom_own_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                SLOT      = 3,
    parameter logic [ADDR_W-1:0] MODE_BASE = 16'hC058
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase0,
    input  logic              phase1_rise,
    input  logic              mb_sel_n,
    input  logic              int_cx_rom,
    input  logic [ADDR_W-1:0] addr,
    output logic              mode80,
    output logic              xwin_active,
    output logic              rom_sel,
    output logic              vram_sel
);
    addr_class_t cls;
    logic        own;

    xrom_addr_class #(
        .ADDR_W    (ADDR_W),
        .SLOT      (SLOT),
        .MODE_BASE (MODE_BASE)
    ) u_class (
        .addr (addr),
        .cls  (cls)
    );

    xrom_own_track u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase0     (phase0),
        .int_cx_rom (int_cx_rom),
        .hit_own    (cls.own_page),
        .hit_other  (cls.other_page),
        .hit_cfff   (cls.cfff),
        .own        (own)
    );

    xrom_mode_latch u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase1_rise (phase1_rise),
        .mb_sel_n    (mb_sel_n),
        .hit_off     (cls.mode_off),
        .hit_on      (cls.mode_on),
        .mode80      (mode80)
    );

    assign xwin_active = own && !int_cx_rom;
    assign rom_sel     = phase0 && xwin_active && (cls.rom_lo || cls.rom_hi);
    assign vram_sel    = phase0 && xwin_active && cls.vram;

endmodule

// File: rtl/xrom_own_decoder_chk.sv
module xrom_own_decoder_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_BASE = 16'hC058
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase0,
    input logic              phase1_rise,
    input logic              mb_sel_n,
    input logic              int_cx_rom,
    input logic [ADDR_W-1:0] addr,
    input logic              mode80,
    input logic              xwin_active,
    input logic              rom_sel,
    input logic              vram_sel
);
    localparam logic [ADDR_W-1:0] STROBE = {4'hC, {(ADDR_W-4){1'b1}}};

    // R6
    win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xwin_active |-> !int_cx_rom);

    // R8
    rom_not_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (addr != STROBE) && xwin_active && phase0);

    // R7
    vram_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_sel |-> xwin_active && phase0 && !rom_sel);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(phase0) && $stable(int_cx_rom)) |-> $stable(xwin_active));

    // R9
    mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase1_rise && !mb_sel_n && addr == MODE_BASE + ADDR_W'(1)) |=> mode80);

    // R9
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase1_rise && !mb_sel_n && addr == MODE_BASE) |=> !mode80);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase1_rise || mb_sel_n) |=> $stable(mode80));

endmodule

bind xrom_own_decoder xrom_own_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .MODE_BASE (MODE_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase0      (phase0),
    .phase1_rise (phase1_rise),
    .mb_sel_n    (mb_sel_n),
    .int_cx_rom  (int_cx_rom),
    .addr        (addr),
    .mode80      (mode80),
    .xwin_active (xwin_active),
    .rom_sel     (rom_sel),
    .vram_sel    (vram_sel)
);

// File: tb/xrom_own_decoder_bench.sv
`timescale 1ns/100ps
module xrom_own_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase0 = 1'b0;
    logic        phase1_rise = 1'b0;
    logic        mb_sel_n = 1'b1;
    logic        int_cx_rom = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        mode80, xwin_active, rom_sel, vram_sel;

    int compared = 0;
    int mismatched = 0;
    string scen = "R10";

    // behavioural reference state
    int m_own = 0, m_done = 0, m_mode = 0;

    always #2.5 clk = ~clk;

    xrom_own_decoder u_xrom_own_decoder (
        .clk(clk), .rst_n(rst_n), .phase0(phase0), .phase1_rise(phase1_rise),
        .mb_sel_n(mb_sel_n), .int_cx_rom(int_cx_rom), .addr(addr),
        .mode80(mode80), .xwin_active(xwin_active), .rom_sel(rom_sel), .vram_sel(vram_sel)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own = 0; m_done = 0; m_mode = 0;
        end else begin
            int a;
            a = int'(addr);
            if (!phase0) m_done = 0;
            else if (m_done == 0) begin
                if (a >= 'hC300 && a <= 'hC3FF) begin m_own = 1; m_done = 1; end
                else if (a == 'hCFFF && !int_cx_rom) begin m_own = 0; m_done = 1; end
                else if (a >= 'hC100 && a <= 'hC7FF) begin m_own = 0; m_done = 1; end
            end
            if (phase1_rise && !mb_sel_n) begin
                if (a == 'hC058) m_mode = 0;
                else if (a == 'hC059) m_mode = 1;
            end
        end
    end

    task automatic chk(string tag, logic act, int exp);
        compared++;
        if (int'(act) != exp) begin
            mismatched++;
            $display("FAIL %s (scenario %s) addr=%h actual=%0d expected=%0d at %0t",
                     tag, scen, addr, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int a, ew, er, ev;
        a  = int'(addr);
        ew = (m_own != 0 && !int_cx_rom) ? 1 : 0;
        ev = (phase0 && ew != 0 && a >= 'hCC00 && a <= 'hCDFF) ? 1 : 0;
        er = (phase0 && ew != 0 && ((a >= 'hC800 && a <= 'hCBFF) ||
                                     (a >= 'hCE00 && a <= 'hCFFE))) ? 1 : 0;
        chk("R9 mode80", mode80, m_mode);
        chk("R6 xwin_active", xwin_active, ew);
        chk("R7 vram_sel", vram_sel, ev);
        chk("R8 rom_sel", rom_sel, er);
    endtask

    // drive at the falling edge, compare 1 ns later, then wait a full cycle
    task automatic cyc(input logic [15:0] a, input logic p0, input logic p1r = 1'b0,
                       input logic mbn = 1'b1, input logic icx = 1'b0);
        addr = a; phase0 = p0; phase1_rise = p1r; mb_sel_n = mbn; int_cx_rom = icx;
        #1;
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        scen = "R10";
        cyc(16'hC300, 1'b1);
        cyc(16'hC059, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        cyc(16'h0000, 1'b0);

        scen = "R1";
        cyc(16'hC800, 1'b1);          // window closed yet
        cyc(16'hC000, 1'b0);
        cyc(16'hC3FF, 1'b1);          // claim
        cyc(16'hC800, 1'b0);
        cyc(16'hC800, 1'b1);

        scen = "R7";
        cyc(16'hCBFF, 1'b1); cyc(16'hCC00, 1'b1); cyc(16'hCDFF, 1'b1);
        cyc(16'hCE00, 1'b1); cyc(16'hCC80, 1'b0);

        scen = "R8";
        cyc(16'hCFFE, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hCFFF, 1'b1); cyc(16'hC800, 1'b0); cyc(16'hC800, 1'b1);

        scen = "R4";
        cyc(16'hC300, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hCFFF, 1'b0); cyc(16'hC600, 1'b0); cyc(16'hC800, 1'b1);

        scen = "R2";
        cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(16'hCFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        cyc(16'hC800, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(16'hC800, 1'b1, 1'b0, 1'b1, 1'b0);   // still owned
        cyc(16'h0000, 1'b0);

        scen = "R3";
        cyc(16'hC0FF, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hCA00, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC600, 1'b1); cyc(16'h0000, 1'b0); cyc(16'hCC00, 1'b1);
        cyc(16'h0000, 1'b0); cyc(16'hC300, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC2FF, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC300, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC400, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC300, 1'b1); cyc(16'h0000, 1'b0);
        cyc(16'hC7FF, 1'b1); cyc(16'hC800, 1'b1);

        scen = "R5";
        cyc(16'h0000, 1'b0);
        cyc(16'hC300, 1'b1); cyc(16'hCFFF, 1'b1); cyc(16'hC500, 1'b1); cyc(16'hC800, 1'b1);
        cyc(16'h0000, 1'b0);
        cyc(16'hCFFF, 1'b1); cyc(16'hC300, 1'b1); cyc(16'hC800, 1'b1);
        cyc(16'h0000, 1'b0);

        scen = "R9";
        cyc(16'hC059, 1'b0, 1'b1, 1'b1);   // motherboard select inactive
        cyc(16'hC059, 1'b0, 1'b0, 1'b0);   // no phase-1 edge
        cyc(16'hC059, 1'b0, 1'b1, 1'b0);   // set
        cyc(16'hC05A, 1'b0, 1'b1, 1'b0);
        cyc(16'hC058, 1'b0, 1'b1, 1'b1);
        cyc(16'hC058, 1'b0, 1'b1, 1'b0);   // clear
        cyc(16'hC059, 1'b0, 1'b1, 1'b0);

        scen = "R10";
        cyc(16'hC300, 1'b1); cyc(16'h0000, 1'b0);
        #1.2 rst_n = 1'b0;                  // asynchronous, away from the edge
        #0.5;
        compare_all();
        @(negedge clk);
        cyc(16'h0000, 1'b0);
        rst_n = 1'b1;
        cyc(16'h0000, 1'b0);

        scen = "mix";
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int k;
            k = int'($urandom_range(0, 9));
            case (k)
                0: a = 16'hC300 | 16'($urandom_range(0, 255));
                1: a = 16'hCFFF;
                2: a = 16'hC100 | 16'($urandom_range(0, 1023));
                3: a = 16'hC058 | 16'($urandom_range(0, 1));
                4, 5: a = 16'hC800 | 16'($urandom_range(0, 2047));
                6: a = 16'hC600 | 16'($urandom_range(0, 255));
                default: a = 16'($urandom);
            endcase
            cyc(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule